// File: doc/BRIEF.md
# Table-Driven Twin State Machine

This block runs a finite state machine whose whole behaviour sits in a synchronous lookup memory. Each machine builds its read address from its present state code and its condition inputs. Each stored word returns two things: the state code for the next cycle and a small group of output flags. The memory's registered read data is itself the state register and the output register. No other storage sits in the loop.

Two read ports share one table, so two machines follow identical transition rules. Each machine has its own clock, reset, condition inputs, state code and flags. A load port fills the table while both machines are held in reset. Every address holds a defined entry, so recovery from unused state codes is whatever the table says.

Top module: `lutfsm_dual`

## Requirements
- R1: The read address is `{state, cond}`, with the state code in the upper ST_W bits and the condition inputs in the lower CND_W bits. Each stored word is `{flags, next_state}`, with the next state in the low ST_W bits.
- R2: A machine whose reset is high at a rising edge of its clock shows state START (default 0) and all-zero flags after that edge. At the first edge after release it reads entry `{START, cond}`.
- R3: At a rising edge of `clk_a`, `ld_data` is written to `ld_addr` when `ld_en`, `rst_a` and `rst_b` are all high.
- R4: A load request made while either machine is out of reset leaves the table unchanged.
- R5: The two machines share the table but run independently. Each one's trajectory depends only on its own clock, reset and condition stream, and a reset of one leaves the other's sequence undisturbed.
- R6: A state code that the table never uses for normal operation goes to whatever its table entries specify. In the test table, codes above 4 return to state 0 with flags 3'b100, and condition `4'b11xx` sends any legal state to code 31.
- R7: The flags are updated on the same edge as the state code, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Clock of machine A; also clocks table loads |
| rst_a | input | 1 | Synchronous reset of machine A |
| cond_a | input | CND_W | Condition inputs of machine A |
| state_a | output | ST_W | Current state code of machine A |
| flags_a | output | OUT_W | Current output flags of machine A |
| clk_b | input | 1 | Clock of machine B |
| rst_b | input | 1 | Synchronous reset of machine B |
| cond_b | input | CND_W | Condition inputs of machine B |
| state_b | output | ST_W | Current state code of machine B |
| flags_b | output | OUT_W | Current output flags of machine B |
| ld_en | input | 1 | Table write request |
| ld_addr | input | ST_W+CND_W | Table entry to write |
| ld_data | input | ST_W+OUT_W | Word to write |

## Verification
The state code is fed straight back into the address. A wrong entry, a wrong field split or a stray write therefore shows on `state_a`/`state_b` one edge after the bad read. From then on every later step follows the wrong trajectory, so the fault also spreads into the flags. A write that slipped through during run mode shows up the first time a machine visits the corrupted address. The bench aims one machine's first step at exactly such an entry, so that fault surfaces one cycle after release.

// File: rtl/lutfsm_pkg.sv
`timescale 1ns/1ps
package lutfsm_pkg;
  localparam int NPORT = 2;

  function automatic int addr_bits(input int st_w, input int cnd_w);
    return st_w + cnd_w;
  endfunction

  function automatic int word_bits(input int st_w, input int out_w);
    return st_w + out_w;
  endfunction

  function automatic int table_depth(input int st_w, input int cnd_w);
    return 1 << (st_w + cnd_w);
  endfunction
endpackage

// File: rtl/lutfsm_port.sv
`timescale 1ns/1ps
module lutfsm_port #(
  parameter int ST_W  = 5,
  parameter int CND_W = 4,
  parameter int OUT_W = 3,
  localparam int AW = lutfsm_pkg::addr_bits(ST_W, CND_W),
  localparam int WW = lutfsm_pkg::word_bits(ST_W, OUT_W)
) (
  input  logic [WW-1:0]    word,
  input  logic [CND_W-1:0] cond,
  output logic [AW-1:0]    addr,
  output logic [ST_W-1:0]  state,
  output logic [OUT_W-1:0] flags
);
  // word layout: {flags, next_state}
  function automatic logic [ST_W-1:0] state_field(input logic [WW-1:0] w);
    return w[ST_W-1:0];
  endfunction

  function automatic logic [OUT_W-1:0] flag_field(input logic [WW-1:0] w);
    return w[WW-1:ST_W];
  endfunction

  // address layout: {state, cond}
  function automatic logic [AW-1:0] join_addr(input logic [ST_W-1:0] s,
                                                input logic [CND_W-1:0] c);
    return {s, c};
  endfunction

  assign state = state_field(word);
  assign flags = flag_field(word);
  assign addr  = join_addr(state, cond);
endmodule

// File: rtl/lutfsm_table.sv
`timescale 1ns/1ps
module lutfsm_table #(
  parameter int ST_W  = 5,
  parameter int CND_W = 4,
  parameter int OUT_W = 3,
  parameter int START = 0,
  parameter int NP    = lutfsm_pkg::NPORT,
  localparam int AW    = lutfsm_pkg::addr_bits(ST_W, CND_W),
  localparam int WW    = lutfsm_pkg::word_bits(ST_W, OUT_W),
  localparam int DEPTH = lutfsm_pkg::table_depth(ST_W, CND_W)
) (
  input  logic                   wclk,
  input  logic                   we_req,
  input  logic                   hold,
  input  logic [AW-1:0]          waddr,
  input  logic [WW-1:0]          wdata,
  output logic                   wr_fire,
  input  logic [NP-1:0]          rclk,
  input  logic [NP-1:0]          rrst,
  input  logic [NP-1:0][AW-1:0]  raddr,
  output logic [NP-1:0][WW-1:0]  rword
);
  localparam logic [ST_W-1:0] START_CODE = ST_W'(START);
  localparam logic [WW-1:0]   RESET_WORD = {{OUT_W{1'b0}}, START_CODE};

  logic [WW-1:0] mem [DEPTH];

  // write side: only while every machine is parked in reset
  assign wr_fire = we_req & hold;

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wdata;
  end

  // observation wires for the frozen-table check
  logic [AW-1:0] waddr_q;
  logic [WW-1:0] peek_now, peek_prev;
  always_ff @(posedge wclk) waddr_q <= waddr;
  assign peek_now  = mem[waddr];
  assign peek_prev = mem[waddr_q];

  AST_TABLE_FROZEN: assert property (@(posedge wclk) disable iff (hold)
    we_req |=> peek_prev == $past(peek_now)) else $error("table changed in run mode"); // R4

  // read side: registered data is the state register
  for (genvar g = 0; g < NP; g++) begin : g_rd
    logic [WW-1:0] q;
    always_ff @(posedge rclk[g]) begin
      if (rrst[g]) q <= RESET_WORD;
      else         q <= mem[raddr[g]];
    end
    assign rword[g] = q;

    AST_START_STATE: assert property (@(posedge rclk[g])
      rrst[g] |=> rword[g][ST_W-1:0] == START_CODE) else $error("start code"); // R2
    AST_START_FLAGS: assert property (@(posedge rclk[g])
      rrst[g] |=> rword[g][WW-1:ST_W] == '0) else $error("flags in reset"); // R2
  end
endmodule

// File: rtl/lutfsm_dual.sv
`timescale 1ns/1ps
module lutfsm_dual #(
  parameter int ST_W  = 5,
  parameter int CND_W = 4,
  parameter int OUT_W = 3,
  parameter int START = 0,
  localparam int AW = lutfsm_pkg::addr_bits(ST_W, CND_W),
  localparam int WW = lutfsm_pkg::word_bits(ST_W, OUT_W),
  localparam int NP = lutfsm_pkg::NPORT
) (
  input  logic             clk_a,
  input  logic             rst_a,
  input  logic [CND_W-1:0] cond_a,
  output logic [ST_W-1:0]  state_a,
  output logic [OUT_W-1:0] flags_a,
  input  logic             clk_b,
  input  logic             rst_b,
  input  logic [CND_W-1:0] cond_b,
  output logic [ST_W-1:0]  state_b,
  output logic [OUT_W-1:0] flags_b,
  input  logic             ld_en,
  input  logic [AW-1:0]    ld_addr,
  input  logic [WW-1:0]    ld_data
);
  logic [NP-1:0]            clk_v, rst_v;
  logic [NP-1:0][CND_W-1:0] cond_v;
  logic [NP-1:0][AW-1:0]    addr_v;
  logic [NP-1:0][WW-1:0]    word_v;
  logic [NP-1:0][ST_W-1:0]  state_v;
  logic [NP-1:0][OUT_W-1:0] flags_v;
  logic                     both_parked, wr_fire;

  assign clk_v  = {clk_b, clk_a};
  assign rst_v  = {rst_b, rst_a};
  assign cond_v = {cond_b, cond_a};
  assign both_parked = rst_a & rst_b;

  lutfsm_table #(.ST_W(ST_W), .CND_W(CND_W), .OUT_W(OUT_W), .START(START), .NP(NP)) u_table (
    .wclk(clk_a), .we_req(ld_en), .hold(both_parked), .waddr(ld_addr), .wdata(ld_data),
    .wr_fire(wr_fire), .rclk(clk_v), .rrst(rst_v), .raddr(addr_v), .rword(word_v)
  );

  for (genvar g = 0; g < NP; g++) begin : g_mach
    lutfsm_port #(.ST_W(ST_W), .CND_W(CND_W), .OUT_W(OUT_W)) u_port (
      .word(word_v[g]), .cond(cond_v[g]), .addr(addr_v[g]),
      .state(state_v[g]), .flags(flags_v[g])
    );
  end

  assign state_a = state_v[0];
  assign flags_a = flags_v[0];
  assign state_b = state_v[1];
  assign flags_b = flags_v[1];

  AST_LOAD_GATED: assert property (@(posedge clk_a) disable iff (both_parked)
    !wr_fire) else $error("write accepted in run mode"); // R3
endmodule

// File: tb/lutfsm_dual_test.sv
`timescale 1ns/1ps
module lutfsm_dual_test;
  logic clk_a = 1'b0, clk_b = 1'b0;
  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  logic       rst_a, rst_b, ld_en;
  logic [3:0] cond_a, cond_b;
  logic [4:0] state_a, state_b;
  logic [2:0] flags_a, flags_b;
  logic [8:0] ld_addr;
  logic [7:0] ld_data;

  lutfsm_dual uut (
    .clk_a(clk_a), .rst_a(rst_a), .cond_a(cond_a), .state_a(state_a), .flags_a(flags_a),
    .clk_b(clk_b), .rst_b(rst_b), .cond_b(cond_b), .state_b(state_b), .flags_b(flags_b),
    .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  int vecs = 0, miss = 0;
  bit done = 0;
  logic [4:0] sa, sb;

  // reference: detector for 1011 on cond[0]; flags {0, cond[1], hit}
  function automatic logic [7:0] model_step(input logic [4:0] s, input logic [3:0] c);
    logic [4:0] n;
    if (s > 5'd4) return {3'b100, 5'd0};
    if (c[3:2] == 2'b11) return {3'b000, 5'd31};
    case (s)
      5'd0:    n = c[0] ? 5'd1 : 5'd0;
      5'd1:    n = c[0] ? 5'd1 : 5'd2;
      5'd2:    n = c[0] ? 5'd3 : 5'd0;
      5'd3:    n = c[0] ? 5'd4 : 5'd2;
      default: n = c[0] ? 5'd1 : 5'd2;
    endcase
    return {1'b0, c[1], n == 5'd4, n};
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vecs++;
    if (got !== exp) begin
      miss++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic step_a(input logic [3:0] c, input string req, input bit poke = 0);
    logic [7:0] e;
    @(negedge clk_a);
    rst_a = 1'b0; cond_a = c;
    if (poke) begin ld_en = 1'b1; ld_addr = {5'd0, 4'b0101}; ld_data = 8'hFF; end
    else ld_en = 1'b0;
    @(posedge clk_a); #1;
    e = model_step(sa, c);
    chk(req, {flags_a, state_a}, e);
    sa = e[4:0];
  endtask

  task automatic step_b(input logic [3:0] c, input string req);
    logic [7:0] e;
    @(negedge clk_b);
    rst_b = 1'b0; cond_b = c;
    @(posedge clk_b); #1;
    e = model_step(sb, c);
    chk(req, {flags_b, state_b}, e);
    sb = e[4:0];
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    #200000;
    miss++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h1D5E);
    rst_a = 1'b1; rst_b = 1'b1; ld_en = 1'b0;
    cond_a = '0; cond_b = '0; ld_addr = '0; ld_data = '0;
    sa = 5'd0; sb = 5'd0;
    repeat (2) @(posedge clk_a);

    // fill the table while both machines are parked (R3)
    for (int i = 0; i < 512; i++) begin
      @(negedge clk_a);
      ld_en = 1'b1; ld_addr = 9'(i);
      ld_data = model_step(ld_addr[8:4], ld_addr[3:0]);
    end
    @(negedge clk_a); ld_en = 1'b0;

    // reset state of both machines
    @(posedge clk_a); #1 chk("R2 reset A", {flags_a, state_a}, 8'h00);
    @(posedge clk_b); #1 chk("R2 reset B", {flags_b, state_b}, 8'h00);

    // A runs alone, with write requests aimed at {0,0101} all along (R4)
    for (int k = 0; k < 20; k++) step_a(4'($urandom), "R1 A alone", 1);
    @(negedge clk_a); ld_en = 1'b0;
    // B's first step reads the entry that the ignored writes targeted
    step_b(4'b0101, "R4 ignored load");

    // both machines with their own streams and clocks
    fork
      for (int k = 0; k < 300; k++) step_a(4'($urandom), "R1 R7 A random");
      for (int k = 0; k < 250; k++) step_b(4'($urandom), "R5 B random");
    join

    // illegal-code escape and recovery (R6)
    if (sa > 5'd4) step_a(4'b0000, "R6 settle");
    step_a(4'b1100, "R6 escape to code 31");
    step_a(4'b0011, "R6 recovery from code 31");
    step_a(4'b1111, "R6 escape again");
    step_a(4'b0110, "R6 recovery flags");

    // reset A mid-run while B keeps going (R2, R5)
    fork
      begin
        @(negedge clk_a); rst_a = 1'b1;
        @(posedge clk_a); #1 chk("R2 mid-run reset A", {flags_a, state_a}, 8'h00);
        sa = 5'd0;
        step_a(4'b0001, "R2 first step from start");
        step_a(4'b0000, "R2 second step");
      end
      for (int k = 0; k < 10; k++) step_b(4'($urandom), "R5 B unaffected by A reset");
    join

    // legal rewrite of entry {0,0000} with both parked (R3)
    @(negedge clk_a); rst_a = 1'b1; rst_b = 1'b1;
    repeat (2) @(posedge clk_b);
    @(negedge clk_a); ld_en = 1'b1; ld_addr = 9'h000; ld_data = {3'b010, 5'd3};
    @(negedge clk_a); ld_en = 1'b0; rst_a = 1'b0; cond_a = 4'b0000;
    @(posedge clk_a); #1 chk("R3 rewritten entry", {flags_a, state_a}, {3'b010, 5'd3});

    finish_run();
  end
endmodule